// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block gathers interrupt sources from a low-speed peripheral bus bridge and presents them to the rest of the chip as one interrupt line. It has two stages. The first stage, the inner bank, catches level requests from seventeen serial interrupt channels and single-cycle error and bus-master request events. It holds each one in a sticky status bit that only software can clear. A mask and a global enable decide whether the inner bank raises its summary.

The summary appears as one read-only bit of the outer bank's input register. On every clock edge the outer bank ORs its masked inputs into its own sticky status register. The output line is high while that status is nonzero. Software clears both status registers by writing ones. Both banks sit on one 32-bit register bus with byte offsets. Writes take effect on the clock edge. Reads are combinational.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset every implemented register reads 0 and `irq_out` is low.
- R2: While serial channel n (0..16) is high at a clock edge, inner status (offset 0x38) bit 31−n is set at that edge. The bit stays set after the channel drops.
- R3: A one-cycle pulse sets an inner status bit at that edge. `evt_err[i]` sets bit 2+i, `evt_bm[j]` sets bit j, and `evt_busrst` sets bit 10. An event that coincides with a software clear of the same bit leaves the bit set.
- R4: A write to inner status clears exactly the bits written as one. No other action clears an inner status bit.
- R5: Writes to the inner control (0x30) and inner mask (0x34) registers replace the whole 32-bit value, which then reads back unchanged.
- R6: The inner summary is high exactly when control bit 31 is 1 and (inner status AND inner mask) is nonzero. It reads as bit 11 of the outer input register (0x5C). All other bits of that register read 0, and writes to it are ignored.
- R7: At every edge the outer status (0x50) ORs in (outer input AND outer mask at 0x54). Only a write of ones clears it, and a bit that is being set at the same edge stays set.
- R8: `irq_out` is high exactly while outer status is nonzero. An inner event therefore reaches `irq_out` two edges after it is presented.
- R9: The outer polarity register (0x58) is readable and writable and has no effect on any status or on `irq_out`.
- R10: Reads of any other offset return 0xFFFFFFFF, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W (8) | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| serirq_lvl | input | 17 | Serial interrupt request levels, channel n at index n |
| evt_busrst | input | 1 | Bus reset event pulse |
| evt_err | input | 6 | Sync and turnaround error event pulses |
| evt_bm | input | 2 | Bus-master request event pulses |
| irq_out | output | 1 | Aggregated interrupt output |

## Verification
Each of the seventeen serial channels is raised alone and then dropped. This separates a wrong channel-to-bit mapping from a latch that follows the level instead of holding it. Each event pulse is tried on its own and then together with a clear of the same bit, which shows whether set beats clear. The cascade is swept over every combination of global enable, an inner mask that matches or misses the pending bit, and an outer mask that is on or off. Only one combination may raise the input bit and the output, and only after the second edge. Polarity writes, writes to the input register and accesses to unused offsets are each followed by readbacks and an output check, to show that they leave everything untouched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned NUM_SERIRQ   = 17;
  localparam int unsigned NUM_ERR      = 6;
  localparam int unsigned NUM_BMREQ    = 2;
  // bit positions inside the inner status word
  localparam int unsigned BIT_BUSRST   = 10;
  localparam int unsigned BIT_ERR_LO   = 2;
  localparam int unsigned BIT_BMREQ_LO = 0;
  localparam int unsigned BIT_ENABLE   = 31;
  // bit of the outer input register fed by the inner summary
  localparam int unsigned BIT_SUMMARY  = 11;
  // byte offsets decoded on the register bus
  localparam logic [7:0] OFS_ICTRL = 8'h30;
  localparam logic [7:0] OFS_IMASK = 8'h34;
  localparam logic [7:0] OFS_ISTAT = 8'h38;
  localparam logic [7:0] OFS_OSTAT = 8'h50;
  localparam logic [7:0] OFS_OMASK = 8'h54;
  localparam logic [7:0] OFS_OPOL  = 8'h58;
  localparam logic [7:0] OFS_OIN   = 8'h5C;
endpackage

// File: rtl/irqc_inner_bank.sv
module irqc_inner_bank
  import irqc_pkg::*;
#(
  parameter int unsigned W    = REG_W,
  parameter int unsigned NSER = NUM_SERIRQ,
  parameter int unsigned NERR = NUM_ERR,
  parameter int unsigned NBM  = NUM_BMREQ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic            mask_we,
  input  logic            stat_we,
  input  logic [W-1:0]    wdata,
  input  logic [NSER-1:0] serirq,
  input  logic            busrst_evt,
  input  logic [NERR-1:0] err_evt,
  input  logic [NBM-1:0]  bm_evt,
  output logic [W-1:0]    ctrl_q,
  output logic [W-1:0]    mask_q,
  output logic [W-1:0]    stat_q,
  output logic            summary
);
  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] stat_d;

  // map every source onto its status bit
  always_comb begin
    set_vec = '0;
    for (int n = 0; n < int'(NSER); n++) set_vec[W-1-n] = serirq[n];
    for (int i = 0; i < int'(NERR); i++) set_vec[BIT_ERR_LO+i] = err_evt[i];
    for (int j = 0; j < int'(NBM); j++)  set_vec[BIT_BMREQ_LO+j] = bm_evt[j];
    set_vec[BIT_BUSRST] = busrst_evt;
  end

  // clear first, then set: an arriving event wins over the clear
  always_comb begin
    clr_vec = stat_we ? wdata : '0;
    stat_d  = (stat_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      if (mask_we) mask_q <= wdata;
      if (stat_we || (|set_vec)) stat_q <= stat_d;
    end
  end

  assign summary = ctrl_q[BIT_ENABLE] & (|(stat_q & mask_q));

  // R2/R3: every presented source is latched at the edge
  p_source_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R4: without a status write no bit may fall
  p_sticky_inner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/irqc_outer_bank.sv
module irqc_outer_bank
  import irqc_pkg::*;
#(
  parameter int unsigned W       = REG_W,
  parameter int unsigned SUM_BIT = BIT_SUMMARY
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stat_we,
  input  logic         mask_we,
  input  logic         pol_we,
  input  logic [W-1:0] wdata,
  input  logic         summary,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] input_vec,
  output logic         irq
);
  logic [W-1:0] clr_vec;
  logic [W-1:0] stat_d;

  always_comb begin
    input_vec          = '0;
    input_vec[SUM_BIT] = summary;
    clr_vec            = stat_we ? wdata : '0;
    stat_d             = (stat_q & ~clr_vec) | (input_vec & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      pol_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (mask_we) mask_q <= wdata;
      if (pol_we)  pol_q  <= wdata;
    end
  end

  assign irq = |stat_q;

  // R7: outer status only falls through a write
  p_sticky_outer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [NUM_SERIRQ-1:0] serirq_lvl,
  input  logic                  evt_busrst,
  input  logic [NUM_ERR-1:0]    evt_err,
  input  logic [NUM_BMREQ-1:0]  evt_bm,
  output logic                  irq_out
);
  logic [REG_W-1:0] ictrl, imask, istat, ostat, omask, opol, oin;
  logic             inner_sum;
  logic             hit_ictrl, hit_imask, hit_istat;
  logic             hit_ostat, hit_omask, hit_opol, hit_oin;

  always_comb begin
    hit_ictrl = (reg_addr == ADDR_W'(OFS_ICTRL));
    hit_imask = (reg_addr == ADDR_W'(OFS_IMASK));
    hit_istat = (reg_addr == ADDR_W'(OFS_ISTAT));
    hit_ostat = (reg_addr == ADDR_W'(OFS_OSTAT));
    hit_omask = (reg_addr == ADDR_W'(OFS_OMASK));
    hit_opol  = (reg_addr == ADDR_W'(OFS_OPOL));
    hit_oin   = (reg_addr == ADDR_W'(OFS_OIN));
  end

  irqc_inner_bank #(.W(REG_W), .NSER(NUM_SERIRQ), .NERR(NUM_ERR), .NBM(NUM_BMREQ)) u_inner (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (reg_wr && hit_ictrl),
    .mask_we    (reg_wr && hit_imask),
    .stat_we    (reg_wr && hit_istat),
    .wdata      (reg_wdata),
    .serirq     (serirq_lvl),
    .busrst_evt (evt_busrst),
    .err_evt    (evt_err),
    .bm_evt     (evt_bm),
    .ctrl_q     (ictrl),
    .mask_q     (imask),
    .stat_q     (istat),
    .summary    (inner_sum)
  );

  irqc_outer_bank #(.W(REG_W), .SUM_BIT(BIT_SUMMARY)) u_outer (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_we   (reg_wr && hit_ostat),
    .mask_we   (reg_wr && hit_omask),
    .pol_we    (reg_wr && hit_opol),
    .wdata     (reg_wdata),
    .summary   (inner_sum),
    .stat_q    (ostat),
    .mask_q    (omask),
    .pol_q     (opol),
    .input_vec (oin),
    .irq       (irq_out)
  );

  always_comb begin
    reg_rdata = '1;
    if (hit_ictrl) reg_rdata = ictrl;
    if (hit_imask) reg_rdata = imask;
    if (hit_istat) reg_rdata = istat;
    if (hit_ostat) reg_rdata = ostat;
    if (hit_omask) reg_rdata = omask;
    if (hit_opol)  reg_rdata = opol;
    if (hit_oin)   reg_rdata = oin;
  end

  // R8: a masked inner summary reaches the output one edge later
  p_cascade_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inner_sum && omask[BIT_SUMMARY]) |=> irq_out);

  // R1: output is low on the first edge after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_out);
endmodule

// File: tb/irq_cascade_top_test.sv
module irq_cascade_top_test;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [16:0] serirq_lvl;
  logic        evt_busrst;
  logic [5:0]  evt_err;
  logic [1:0]  evt_bm;
  logic        irq_out;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  irq_cascade_top #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serirq_lvl(serirq_lvl),
    .evt_busrst(evt_busrst), .evt_err(evt_err), .evt_bm(evt_bm), .irq_out(irq_out)
  );

  initial clk = 0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic quiesce();
    wr_reg(8'h30, 32'h0);
    wr_reg(8'h34, 32'h0);
    wr_reg(8'h54, 32'h0);
    wr_reg(8'h38, 32'hFFFF_FFFF);
    wr_reg(8'h50, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests_run++; tests_failed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ev;
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    serirq_lvl = 0; evt_busrst = 0; evt_err = 0; evt_bm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();

    // R1: reset state
    foreach (ev[k]) begin end
    rd_reg(8'h30, v); check("R1 ictrl", v, 0);
    rd_reg(8'h34, v); check("R1 imask", v, 0);
    rd_reg(8'h38, v); check("R1 istat", v, 0);
    rd_reg(8'h50, v); check("R1 ostat", v, 0);
    rd_reg(8'h54, v); check("R1 omask", v, 0);
    rd_reg(8'h58, v); check("R1 opol", v, 0);
    rd_reg(8'h5C, v); check("R1 oin", v, 0);
    check("R1 irq", {31'b0, irq_out}, 0);

    // R2: each serial channel latches at bit 31-n and holds after release
    for (int n = 0; n < 17; n++) begin
      ev = 32'h1 << (31 - n);
      serirq_lvl = 17'h1 << n;
      tick();
      rd_reg(8'h38, v); check("R2 set", v, ev);
      serirq_lvl = 0;
      tick();
      rd_reg(8'h38, v); check("R2 hold", v, ev);
      wr_reg(8'h38, ev);
      rd_reg(8'h38, v); check("R4 clear", v, 0);
    end

    // R3: event pulses, bit = 2+i / j / 10
    for (int k = 0; k < 9; k++) begin
      ev = (k < 6) ? (32'h4 << k) : (k < 8) ? (32'h1 << (k - 6)) : 32'h400;
      if (k < 6) evt_err[k] = 1; else if (k < 8) evt_bm[k-6] = 1; else evt_busrst = 1;
      tick();
      evt_err = 0; evt_bm = 0; evt_busrst = 0;
      rd_reg(8'h38, v); check("R3 event", v, ev);
      tick();
      rd_reg(8'h38, v); check("R3 hold", v, ev);
      wr_reg(8'h38, ev);
    end

    // R3/R4: set beats clear; the other written-one bit clears, others stay
    serirq_lvl = 17'h9;  // bits 31 and 28
    tick();
    serirq_lvl = 0;
    evt_err[0] = 1;
    wr_reg(8'h38, 32'h1000_0004);
    evt_err = 0;
    rd_reg(8'h38, v); check("R3 set wins clear", v, 32'h8000_0004);
    wr_reg(8'h38, 32'hFFFF_FFFF);
    rd_reg(8'h38, v); check("R4 clear all", v, 0);

    // R5: control and mask replace their value
    wr_reg(8'h30, 32'h4300_00A5);
    wr_reg(8'h34, 32'h1234_5678);
    rd_reg(8'h30, v); check("R5 ictrl", v, 32'h4300_00A5);
    rd_reg(8'h34, v); check("R5 imask", v, 32'h1234_5678);
    wr_reg(8'h34, 32'h0000_0001);
    rd_reg(8'h34, v); check("R5 imask replace", v, 32'h0000_0001);
    quiesce();

    // R6/R7/R8: sweep enable x inner mask x outer mask
    for (int en = 0; en < 2; en++)
      for (int mm = 0; mm < 2; mm++)
        for (int om = 0; om < 2; om++) begin
          logic sum;
          quiesce();
          serirq_lvl = 17'h8;   // channel 3 -> bit 28
          tick();
          serirq_lvl = 0;
          wr_reg(8'h34, mm ? 32'h1000_0000 : 32'h2000_0000);
          wr_reg(8'h54, om ? 32'h0000_0800 : 32'h0);
          wr_reg(8'h30, en ? 32'h8000_0000 : 32'h0);
          sum = (en == 1) && (mm == 1);
          rd_reg(8'h5C, v); check("R6 summary bit", v, sum ? 32'h800 : 32'h0);
          check("R8 not yet", {31'b0, irq_out}, 0);
          tick();
          check("R8 irq", {31'b0, irq_out}, {31'b0, sum && (om == 1)});
          rd_reg(8'h50, v); check("R7 ostat", v, (sum && om == 1) ? 32'h800 : 32'h0);
        end

    // state now: summary high, outer mask on, outer status 0x800
    // R7: set wins over clear on the outer status
    wr_reg(8'h50, 32'hFFFF_FFFF);
    rd_reg(8'h50, v); check("R7 set wins clear", v, 32'h800);
    check("R8 irq held", {31'b0, irq_out}, 1);
    // R6: writes to the input register are ignored
    wr_reg(8'h5C, 32'hFFFF_FFFF);
    rd_reg(8'h5C, v); check("R6 input ro", v, 32'h800);
    // R9: polarity stored, no effect
    wr_reg(8'h58, 32'hFFFF_FFFF);
    rd_reg(8'h58, v); check("R9 pol", v, 32'hFFFF_FFFF);
    check("R9 irq unaffected", {31'b0, irq_out}, 1);
    // R7: status stays set once the input drops, until cleared
    wr_reg(8'h30, 32'h0);
    rd_reg(8'h5C, v); check("R6 disabled", v, 0);
    tick();
    rd_reg(8'h50, v); check("R7 sticky", v, 32'h800);
    wr_reg(8'h50, 32'h800);
    rd_reg(8'h50, v); check("R7 cleared", v, 0);
    check("R8 irq low", {31'b0, irq_out}, 0);
    wr_reg(8'h58, 32'h0);
    check("R9 irq still low", {31'b0, irq_out}, 0);

    // R10: unimplemented offsets
    wr_reg(8'h34, 32'h0000_00F0);
    wr_reg(8'h54, 32'h0000_0800);
    foreach (ev[b]) begin end
    for (int a = 0; a < 256; a += 4) begin
      logic [7:0] ad;
      ad = 8'(a);
      if (ad != 8'h30 && ad != 8'h34 && ad != 8'h38 && ad != 8'h50 &&
          ad != 8'h54 && ad != 8'h58 && ad != 8'h5C) begin
        wr_reg(ad, 32'hFFFF_FFFF);
        rd_reg(ad, v); check("R10 unimpl read", v, 32'hFFFF_FFFF);
      end
    end
    rd_reg(8'h30, v); check("R10 ictrl kept", v, 0);
    rd_reg(8'h34, v); check("R10 imask kept", v, 32'h0000_00F0);
    rd_reg(8'h38, v); check("R10 istat kept", v, 32'h1000_0000);
    rd_reg(8'h54, v); check("R10 omask kept", v, 32'h0000_0800);
    rd_reg(8'h58, v); check("R10 opol kept", v, 0);
    check("R10 irq", {31'b0, irq_out}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule